// File: doc/BRIEF.md
# Sigma-delta bitstream receiver

This block takes the one-bit output stream of an external sigma-delta modulator on a single input channel and hands the recovered bits, one per bit period, to a downstream decimation filter. Each recovered bit comes out with a one-cycle valid strobe, both as a plain bit and as a signed sample. A 1 becomes +1 and a 0 becomes -1, so the filter integrates the stream symmetrically about zero.

The receiver handles two kinds of link. The first is a clocked serial link, where a bit clock comes with the data and the data is captured on a selectable edge. The second is a self-clocked Manchester link in either polarity. For clocked links the bit clock comes from one of four sources:

- an external clock pin;
- a free-running clock that the block generates and drives out to the modulator;
- that generated clock divided by two, captured on the divided clock's falling edge;
- that generated clock divided by two, captured on the divided clock's rising edge.

The data can come from the channel's own pin or from the neighbouring channel's pin. Every pin is synchronised into the system clock, and all edges are found there. The system clock must therefore run at least four times the bit rate.

Top module: `sd_bit_rx`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with `en_i` low, `bit_valid_o` is 0 and `sample_o` is 0. Clocks and data that toggle while the channel is disabled produce no bits.
- R2: With `if_type_i` = 0 and `clk_sel_i` = 0 (external clock), the data level present at each rising edge of `ext_clk_i` is delivered as one bit, in order.
- R3: With `if_type_i` = 1 and `clk_sel_i` = 0, the data level present at each falling edge of `ext_clk_i` is delivered as one bit, in order.
- R4: With `if_type_i` = 2 (Manchester), a mid-bit rising transition decodes as 0 and a falling one as 1. `half_bit_i` gives the nominal half-bit length in system clocks.
- R5: With `if_type_i` = 3 (Manchester, inverted), a mid-bit rising transition decodes as 1 and a falling one as 0.
- R6: `int_clk_o` is a free-running square wave with a high time and a low time of `CKO_HALF` system clocks each. With `clk_sel_i` = 1 it is the bit clock, captured on its rising edge for `if_type_i` = 0 and on its falling edge for `if_type_i` = 1.
- R7: With `clk_sel_i` = 2 or 3, a divide-by-two of `int_clk_o` clocks the capture. The divider starts low when the channel is enabled and toggles on each rising edge of `int_clk_o`. Value 2 captures on the divided clock's falling edge and value 3 on its rising edge, whatever `if_type_i[0]` holds.
- R8: With `alt_sel_i` = 1 the data comes from `sd_data_nbr_i`, and `sd_data_i` has no effect on the bits.
- R9: In a valid cycle `sample_o` is +1 (2'b01) for a 1 and -1 (2'b11) for a 0. In any other cycle it is 0.
- R10: Clearing `en_i` drops the Manchester lock and the clock divider. Enabling while the selected clock sits high yields no bit. After re-enable, a Manchester stream is acquired afresh.
- R11: Once locked, the Manchester decoder ignores transitions at bit boundaries, so runs of equal bits decode correctly.
- R12: `bit_valid_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| if_type_i | input | 2 | Link type: 0 serial rising, 1 serial falling, 2 Manchester, 3 Manchester inverted |
| clk_sel_i | input | 2 | Bit clock source: 0 external pin, 1 generated clock, 2 generated/2 falling, 3 generated/2 rising |
| alt_sel_i | input | 1 | Take data from the neighbouring channel's pin |
| half_bit_i | input | HB_W | Manchester nominal half-bit length in system clocks |
| sd_data_i | input | 1 | Own modulator data pin |
| sd_data_nbr_i | input | 1 | Neighbouring channel's data pin |
| ext_clk_i | input | 1 | External bit clock pin |
| int_clk_o | output | 1 | Generated bit clock driven out to the modulator |
| bit_valid_o | output | 1 | One-cycle strobe per recovered bit |
| bit_o | output | 1 | Recovered bit |
| sample_o | output | 2 | Signed sample, +1 or -1 when valid, otherwise 0 |

## Verification
The bench goes after the points where the capture edge could slip. If falling and rising capture were swapped, every bit would be taken half a period off and would read the neighbouring bit. If the divide-by-two phase or its edge choice were wrong, it would return each bit twice or pick up the wrong half of a pair. For Manchester it uses runs of equal bits, and it re-enables the channel after a stream was cut off. A decoder that honoured boundary transitions, or kept a stale lock, would emit extra or inverted bits. It also enables the channel while the clock sits high, and it drives the unused data pin with the complement. An edge detector that remembered an old level, or a data mux that leaked the other pin, would then show up as an unexpected or wrong bit.

// File: rtl/sd_rx_pkg.sv
package sd_rx_pkg;
  typedef enum logic [1:0] {
    IF_SER_RISE = 2'd0,
    IF_SER_FALL = 2'd1,
    IF_MAN      = 2'd2,
    IF_MAN_INV  = 2'd3
  } if_type_e;

  typedef enum logic [1:0] {
    CK_EXT   = 2'd0,
    CK_INT   = 2'd1,
    CK_DIV_F = 2'd2,
    CK_DIV_R = 2'd3
  } ck_sel_e;
endpackage

// File: rtl/sd_rx_sync.sv
module sd_rx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) st_q[g] <= '0;
          else         st_q[g] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) st_q[g] <= '0;
          else         st_q[g] <= st_q[g-1];
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sd_rx_clkgen.sv
module sd_rx_clkgen #(
  parameter int CKO_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic int_clk_o,
  output logic int_dly_o,
  output logic div2_o
);
  localparam int CW = ($clog2(CKO_HALF) > 0) ? $clog2(CKO_HALF) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(CKO_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          cko_q;
  logic          dly_prev_q;
  logic          div_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      cko_q <= 1'b0;
    end else if (cnt_q == CNT_END) begin
      cnt_q <= '0;
      cko_q <= ~cko_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end

  // delay the generated clock like the data pins so edges line up
  sd_rx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cko_q),
    .q_o   (int_dly_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dly_prev_q <= 1'b0;
      div_q      <= 1'b0;
    end else begin
      dly_prev_q <= int_dly_o;
      if (!en_i)                         div_q <= 1'b0;
      else if (int_dly_o && !dly_prev_q) div_q <= ~div_q;
    end

  assign int_clk_o = cko_q;
  assign div2_o    = div_q;
endmodule

// File: rtl/sd_rx_manch.sv
module sd_rx_manch #(
  parameter int HB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            din_i,
  input  logic            inv_i,
  input  logic [HB_W-1:0] half_bit_i,
  output logic            valid_o,
  output logic            bit_o
);
  localparam int TW = HB_W + 2;

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] thr_lo;
  logic [TW-1:0] thr_hi;
  logic          d_q;
  logic          lock_q;
  logic          tr;
  logic          mid;

  // mid-bit window opens at 1.5 half-bits, lock lost past 2.5 half-bits
  assign thr_lo = TW'(half_bit_i) + TW'(half_bit_i >> 1);
  assign thr_hi = thr_lo + TW'(half_bit_i);
  assign tr     = din_i ^ d_q;
  assign mid    = tr && (tmr_q > thr_lo);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      d_q    <= 1'b0;
      lock_q <= 1'b0;
      tmr_q  <= '0;
    end else if (!en_i) begin
      d_q    <= din_i;
      lock_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      d_q <= din_i;
      if (mid) begin
        lock_q <= 1'b1;
        tmr_q  <= '0;
      end else begin
        if (tr && !lock_q)      tmr_q <= '0;
        else if (tmr_q != '1)   tmr_q <= tmr_q + 1'b1;
        if (lock_q && tmr_q > thr_hi) lock_q <= 1'b0;
      end
    end

  assign valid_o = en_i && mid;
  assign bit_o   = inv_i ? din_i : ~din_i;
endmodule

// File: rtl/sd_bit_rx.sv
module sd_bit_rx
  import sd_rx_pkg::*;
#(
  parameter int CKO_HALF    = 4,
  parameter int HB_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        if_type_i,
  input  logic [1:0]        clk_sel_i,
  input  logic              alt_sel_i,
  input  logic [HB_W-1:0]   half_bit_i,
  input  logic              sd_data_i,
  input  logic              sd_data_nbr_i,
  input  logic              ext_clk_i,
  output logic              int_clk_o,
  output logic              bit_valid_o,
  output logic              bit_o,
  output logic signed [1:0] sample_o
);
  logic [1:0] pin_s;
  logic       ext_s;
  logic       din_s;
  logic       int_dly;
  logic       div2;
  logic       sel_ck;
  logic       ck_q;
  logic       rise;
  logic       fall;
  logic       cap;
  logic       man_v;
  logic       man_b;
  logic       is_man;
  logic       nxt_v;
  logic       nxt_b;
  logic       valid_q;
  logic       bit_q;
  logic signed [1:0] smp_q;
  ck_sel_e    ck_sel;

  assign ck_sel = ck_sel_e'(clk_sel_i);
  assign is_man = if_type_i[1];

  sd_rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_clk_i, alt_sel_i ? sd_data_nbr_i : sd_data_i}),
    .q_o   (pin_s)
  );
  assign ext_s = pin_s[1];
  assign din_s = pin_s[0];

  sd_rx_clkgen #(.CKO_HALF(CKO_HALF), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .int_clk_o(int_clk_o),
    .int_dly_o(int_dly),
    .div2_o   (div2)
  );

  always_comb begin
    unique case (ck_sel)
      CK_EXT:  sel_ck = ext_s;
      CK_INT:  sel_ck = int_dly;
      default: sel_ck = div2;
    endcase
  end

  // edge memory follows the selected clock at all times: no edge at enable
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ck_q <= 1'b0;
    else         ck_q <= sel_ck;

  assign rise = sel_ck & ~ck_q;
  assign fall = ~sel_ck & ck_q;

  always_comb begin
    unique case (ck_sel)
      CK_DIV_F: cap = fall;
      CK_DIV_R: cap = rise;
      default:  cap = (if_type_e'(if_type_i) == IF_SER_FALL) ? fall : rise;
    endcase
  end

  sd_rx_manch #(.HB_W(HB_W)) u_manch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i && is_man),
    .din_i     (din_s),
    .inv_i     (if_type_i[0]),
    .half_bit_i(half_bit_i),
    .valid_o   (man_v),
    .bit_o     (man_b)
  );

  assign nxt_v = en_i && (is_man ? man_v : cap);
  assign nxt_b = is_man ? man_b : din_s;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      smp_q   <= '0;
    end else begin
      valid_q <= nxt_v;
      if (nxt_v) bit_q <= nxt_b;
      smp_q   <= !nxt_v ? 2'sd0 : (nxt_b ? 2'sd1 : -2'sd1);
    end

  assign bit_valid_o = valid_q;
  assign bit_o       = bit_q;
  assign sample_o    = smp_q;
endmodule

// File: rtl/sd_bit_rx_chk.sv
module sd_bit_rx_chk #(
  parameter int CKO_HALF = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              bit_valid_o,
  input logic              bit_o,
  input logic signed [1:0] sample_o,
  input logic              int_clk_o
);
  // R1
  dis_no_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bit_valid_o);

  // R9
  sample_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> (sample_o == (bit_o ? 2'sd1 : -2'sd1)));

  // R9
  sample_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> (sample_o == 2'sd0));

  // R12
  no_back2back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  generate
    if (CKO_HALF > 1) begin : g_cko
      // R6
      int_clk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(int_clk_o) |=> int_clk_o);
    end
  endgenerate
endmodule

bind sd_bit_rx sd_bit_rx_chk #(.CKO_HALF(CKO_HALF)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .bit_valid_o(bit_valid_o),
  .bit_o      (bit_o),
  .sample_o   (sample_o),
  .int_clk_o  (int_clk_o)
);

// File: tb/sd_bit_rx_test.sv
module sd_bit_rx_test;
  localparam int CKO = 4;
  localparam int HB  = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic [1:0] if_type_i = 2'd0;
  logic [1:0] clk_sel_i = 2'd0;
  logic alt_sel_i = 1'b0;
  logic [7:0] half_bit_i = 8'(HB);
  logic sd_data_i = 1'b0;
  logic sd_data_nbr_i = 1'b0;
  logic ext_clk_i = 1'b0;
  logic int_clk_o;
  logic bit_valid_o;
  logic bit_o;
  logic signed [1:0] sample_o;

  int n_chk = 0;
  int n_fail = 0;
  bit exp_q[$];
  string cur_req = "R1";
  logic prev_v = 1'b0;
  logic alt_on = 1'b0;

  sd_bit_rx #(.CKO_HALF(CKO), .HB_W(8), .SYNC_STAGES(2)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .if_type_i(if_type_i),
    .clk_sel_i(clk_sel_i), .alt_sel_i(alt_sel_i), .half_bit_i(half_bit_i),
    .sd_data_i(sd_data_i), .sd_data_nbr_i(sd_data_nbr_i), .ext_clk_i(ext_clk_i),
    .int_clk_o(int_clk_o), .bit_valid_o(bit_valid_o), .bit_o(bit_o),
    .sample_o(sample_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // per-clock reference comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (bit_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected bit", int'(bit_o), -1);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(bit_o == e, cur_req, "bit value", int'(bit_o), int'(e));
        end
        chk(sample_o == (bit_o ? 2'sd1 : -2'sd1), "R9", "valid sample",
            int'(sample_o), bit_o ? 1 : -1);
        chk(!prev_v, "R12", "back-to-back valid", int'(prev_v), 0);
      end else if (sample_o != 2'sd0) begin
        chk(1'b0, "R9", "idle sample", int'(sample_o), 0);
      end
      prev_v = bit_valid_o;
    end
  end

  task automatic drive_data(input logic b);
    if (alt_on) begin
      sd_data_nbr_i = b;
      sd_data_i     = ~b;
    end else begin
      sd_data_i     = b;
      sd_data_nbr_i = ~b;
    end
  endtask

  task automatic drain(input string req);
    repeat (20) @(negedge clk_i);
    chk(exp_q.size() == 0, req, "bits left undelivered", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic ser_ext(input logic [1:0] typ, input logic [31:0] w,
                         input int n, input logic push, input string req);
    cur_req   = req;
    if_type_i = typ;
    clk_sel_i = 2'd0;
    ext_clk_i = typ[0];
    repeat (6) @(negedge clk_i);
    if (push) en_i = 1'b1;
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < n; i++) begin
      drive_data(w[i]);
      if (push) exp_q.push_back(w[i]);
      repeat (4) @(negedge clk_i);
      ext_clk_i = ~ext_clk_i;
      repeat (4) @(negedge clk_i);
      ext_clk_i = ~ext_clk_i;
    end
    repeat (8) @(negedge clk_i);
    en_i = 1'b0;
    drain(req);
  endtask

  task automatic wait_int(input logic lvl);
    logic p;
    do begin
      p = int_clk_o;
      @(negedge clk_i);
    end while (!(int_clk_o == lvl && p != lvl));
  endtask

  task automatic int_run(input logic [1:0] sel, input logic [1:0] typ,
                         input logic [31:0] w, input int n, input string req);
    int per;
    logic chg;
    cur_req   = req;
    clk_sel_i = sel;
    if_type_i = typ;
    per = (sel == 2'd1) ? 1 : 2;
    chg = (sel == 2'd1) ? typ[0] : 1'b0;
    wait_int(chg);
    en_i = 1'b1;
    drive_data(w[0]);
    exp_q.push_back(w[0]);
    for (int i = 1; i < n; i++) begin
      repeat (per) wait_int(chg);
      drive_data(w[i]);
      exp_q.push_back(w[i]);
    end
    repeat (per) wait_int(chg);
    en_i = 1'b0;
    drain(req);
  endtask

  task automatic manch(input logic [1:0] typ, input logic [31:0] w,
                       input int n, input int cut, input string req);
    logic fh;
    cur_req   = req;
    if_type_i = typ;
    clk_sel_i = 2'd2;
    fh = typ[0] ? ~w[0] : w[0];
    drive_data(fh);
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    repeat (5 * HB) @(negedge clk_i);
    for (int i = 0; i < n; i++) begin
      fh = typ[0] ? ~w[i] : w[i];
      if (i == cut) en_i = 1'b0;
      drive_data(fh);
      if (en_i) exp_q.push_back(w[i]);
      repeat (HB) @(negedge clk_i);
      drive_data(~fh);
      repeat (HB) @(negedge clk_i);
    end
    repeat (5 * HB) @(negedge clk_i);
    en_i = 1'b0;
    drain(req);
  endtask

  initial begin
    #800000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int t0;
    int t1;
    repeat (3) @(negedge clk_i);
    chk(bit_valid_o == 1'b0, "R1", "valid in reset", int'(bit_valid_o), 0);
    chk(sample_o == 2'sd0, "R1", "sample in reset", int'(sample_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(bit_valid_o == 1'b0, "R1", "valid after reset", int'(bit_valid_o), 0);

    // R1: disabled channel ignores a toggling clock and data
    ser_ext(2'd0, 32'h0000_00B5, 8, 1'b0, "R1");

    // R2 rising capture, R3 falling capture
    ser_ext(2'd0, 32'h0000_A3C5, 16, 1'b1, "R2");
    ser_ext(2'd1, 32'h0000_5C3A, 16, 1'b1, "R3");

    // R8: data from the neighbour pin, own pin carries the complement
    alt_on = 1'b1; alt_sel_i = 1'b1;
    ser_ext(2'd0, 32'h0000_96E1, 16, 1'b1, "R8");
    alt_on = 1'b0; alt_sel_i = 1'b0;

    // R6: generated clock period
    wait_int(1'b1);
    t0 = 0;
    do begin
      t0++;
      @(negedge clk_i);
    end while (int_clk_o);
    t1 = 0;
    do begin
      t1++;
      @(negedge clk_i);
    end while (!int_clk_o);
    chk(t0 == CKO, "R6", "int_clk_o high time", t0, CKO);
    chk(t1 == CKO, "R6", "int_clk_o low time", t1, CKO);
    int_run(2'd1, 2'd0, 32'h0000_4D2B, 16, "R6");
    int_run(2'd1, 2'd1, 32'h0000_B2D4, 16, "R6");

    // R7: halved clock, each edge; if_type_i[0] varied to show it is ignored
    int_run(2'd2, 2'd1, 32'h0000_71E8, 16, "R7");
    int_run(2'd3, 2'd0, 32'h0000_8E17, 16, "R7");

    // R4 / R5 Manchester, R11 runs of equal bits
    manch(2'd2, 32'h00F0_A5C3, 24, 99, "R4");
    manch(2'd3, 32'h003C_5A0F, 24, 99, "R5");
    manch(2'd2, 32'h0000_FF00, 16, 99, "R11");

    // R10: cut a Manchester stream, then re-acquire from scratch
    manch(2'd3, 32'h0000_6E59, 16, 6, "R10");
    manch(2'd3, 32'h0000_E3A6, 16, 99, "R10");

    // R10: enable while external clock sits high, no bit appears
    cur_req = "R10";
    clk_sel_i = 2'd0; if_type_i = 2'd0; ext_clk_i = 1'b1;
    repeat (6) @(negedge clk_i);
    en_i = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(exp_q.size() == 0, "R10", "no bit on enable with clock high", 0, 0);
    en_i = 1'b0;
    ext_clk_i = 1'b0;
    drain("R10");

    summary();
    $finish;
  end
endmodule